// File: doc/BRIEF.md
# Hot-Swap Fault Supervisor

This block holds the digital decisions of a hot-swap power switch controller. It receives already-synchronized comparator results for overvoltage, undervoltage, card presence (low means a card is seated), the level of an external enable pin, and a flag that reports current through the switch. It also receives a millisecond tick and a one-cycle pulse that marks the moment the internal supply leaves lockout. From these it decides whether the external switch may conduct (`gate_en`). It also raises a one-cycle fast-discharge strobe (`gate_pd`) whenever a fault forces the switch off.

Three small registers are kept. A control register holds two autoretry enables and the switch-on command. A status register shows which conditions are live at this moment. A fault register keeps sticky copies of events until they are cleared. Recovery after an overvoltage or undervoltage event is qualified: the condition has to stay away for `QUAL_TICKS` ticks before the switch may turn on again. Seating a card wipes the recorded faults. Once the card has been seated for the same qualification time, the enable pin level is copied into the switch-on command. Software reaches the control register and the fault register through a one-cycle write port.

Top module: `hsw_fault_ctrl`

## Requirements
- R1: While `ov_flag` is 1, `gate_en` is 0 in the same cycle and status bit 0 is 1. A rising edge of `ov_flag` sets fault bit 0 on the next clock.
- R2: While `uv_flag` is 1, `gate_en` is 0 in the same cycle and status bit 1 is 1. A rising edge of `uv_flag` sets fault bit 1 on the next clock.
- R3: After an overvoltage or undervoltage condition ends, the switch stays blocked until `QUAL_TICKS` ticks have been seen with that condition continuously absent. The retry needs control bit 0 (for overvoltage) or bit 1 (for undervoltage) to be set. If the condition returns before the count completes, the count starts again from zero.
- R4: While a fault's autoretry bit is 0, its block is kept no matter how long the condition stays away. Only a new card insertion lifts it.
- R5: A `uvlo_rel` pulse in a cycle where `uv_flag` is 1 sets fault bit 1, even if `uv_flag` has no rising edge.
- R6: Every change of `bd_n` sets fault bit 4.
- R7: When `bd_n` rises (card removed), `gate_en` is 0 in that same cycle, status bit 4 reads 0, and control bit 3 is cleared on the next clock.
- R8: When `bd_n` falls (card inserted), status bit 4 reads 1. Fault bits 0, 1 and 5 are cleared on the next clock, unless a new event sets them in that cycle. The overvoltage and undervoltage blocks are lifted.
- R9: On the `QUAL_TICKS`-th tick with `bd_n` held low, control bit 3 takes the level of `on_pin`. `gate_en` is 1 exactly when control bit 3 is 1, both flags are 0, `bd_n` is 0 and no retry block is active.
- R10: Status bit 5 equals `fet_short` AND NOT `gate_en`. When that bit is 1, fault bit 5 is set on the next clock.
- R11: A write with `wr_sel`=1 clears every fault bit whose `wr_data` bit is 1 (write-1-to-clear). A set event in the same cycle wins over the clear.
- R12: A write with `wr_sel`=0 loads control bits 0, 1 and 3 from `wr_data` bits 0, 1 and 3. In the same cycle, an insertion load of bit 3 takes priority over the write, and a removal takes priority over both. Reset gives control = 0x03, fault = 0x00, `gate_en` = 0.
- R13: `gate_pd` is 1 for exactly one cycle when `gate_en` goes from 1 to 0 while a flag is set or `bd_n` is 1. A turn-off caused only by software does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle millisecond tick |
| uvlo_rel | input | 1 | Pulse: internal supply has left lockout |
| ov_flag | input | 1 | Overvoltage comparator result |
| uv_flag | input | 1 | Undervoltage comparator result |
| bd_n | input | 1 | Card presence, 0 = seated |
| on_pin | input | 1 | Enable pin level |
| fet_short | input | 1 | Current seen through the switch |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = fault clear |
| wr_data | input | 8 | Write data |
| ctl_a | output | 8 | Control register (bit0 OV retry, bit1 UV retry, bit3 switch on) |
| stat_c | output | 8 | Live status (bit0 OV, bit1 UV, bit4 card seated, bit5 short) |
| flt_d | output | 8 | Sticky faults (bit0 OV, bit1 UV, bit4 card change, bit5 short) |
| gate_en | output | 1 | Switch enable |
| gate_pd | output | 1 | One-cycle fast pulldown strobe |

## Verification
The bench builds the block with `QUAL_TICKS` = 4, so that one qualification interval costs only four ticks. With that value, full retry, re-qualification after an interrupted count and insertion loading all occur many times within a short random run. At this size the cycle where a count completes, and the cycle just before it, can both be hit directly. That brings the off-by-one boundary of the counters, and collisions of writes with insertion events, within reach of both the directed cases and the random stimulus.

// File: rtl/hsw_fault_ctrl.sv
module hsw_fault_ctrl #(
  parameter int QUAL_TICKS = 100,
  localparam int CW = $clog2(QUAL_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       uvlo_rel,
  input  logic       ov_flag,
  input  logic       uv_flag,
  input  logic       bd_n,
  input  logic       on_pin,
  input  logic       fet_short,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ctl_a,
  output logic [7:0] stat_c,
  output logic [7:0] flt_d,
  output logic       gate_en,
  output logic       gate_pd
);
  localparam logic [CW-1:0] FULL = CW'(QUAL_TICKS);
  localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);

  logic a0, a1, a3;
  logic ov_blk, uv_blk;
  logic ov_q, uv_q, bd_q, gate_q;
  logic [CW-1:0] ov_cnt, uv_cnt, ins_cnt;
  logic [7:0] d_r;

  wire ins_edge  = bd_q & ~bd_n;
  wire rem_edge  = ~bd_q & bd_n;
  wire ov_rise   = ov_flag & ~ov_q;
  wire uv_rise   = uv_flag & ~uv_q;
  wire ov_rel    = ov_blk & ~ov_flag & (ov_cnt == FULL) & a0;
  wire uv_rel    = uv_blk & ~uv_flag & (uv_cnt == FULL) & a1;
  wire ins_load  = ~bd_n & ms_tick & (ins_cnt == LAST);
  wire wr_a      = wr_en & ~wr_sel;
  wire wr_d      = wr_en & wr_sel;

  assign gate_en = a3 & ~ov_flag & ~uv_flag & ~bd_n & ~ov_blk & ~uv_blk;
  assign gate_pd = gate_q & ~gate_en & (ov_flag | uv_flag | bd_n);

  wire short_now = fet_short & ~gate_en;
  assign stat_c = {2'b00, short_now, ~bd_n, 2'b00, uv_flag, ov_flag};
  assign ctl_a  = {4'b0000, a3, 1'b0, a1, a0};
  assign flt_d  = d_r;

  wire [7:0] d_set = {2'b00, short_now, bd_q ^ bd_n, 2'b00,
                      uv_rise | (uvlo_rel & uv_flag), ov_rise};
  wire [7:0] d_clr = (wr_d ? wr_data : 8'h00) | (ins_edge ? 8'hEF : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a0 <= 1'b1; a1 <= 1'b1; a3 <= 1'b0;
      ov_blk <= 1'b0; uv_blk <= 1'b0;
      ov_cnt <= '0; uv_cnt <= '0; ins_cnt <= '0;
      d_r <= 8'h00;
      gate_q <= 1'b0;
      ov_q <= ov_flag; uv_q <= uv_flag; bd_q <= bd_n;
    end else begin
      ov_q <= ov_flag; uv_q <= uv_flag; bd_q <= bd_n;
      gate_q <= gate_en;
      d_r <= ((d_r & ~d_clr) | d_set) & 8'h33;

      if (wr_a) begin a0 <= wr_data[0]; a1 <= wr_data[1]; end
      if (rem_edge)      a3 <= 1'b0;
      else if (ins_load) a3 <= on_pin;
      else if (wr_a)     a3 <= wr_data[3];

      if (ov_flag) ov_cnt <= '0;
      else if (ms_tick && ov_cnt != FULL) ov_cnt <= ov_cnt + 1'b1;
      if (uv_flag) uv_cnt <= '0;
      else if (ms_tick && uv_cnt != FULL) uv_cnt <= uv_cnt + 1'b1;
      if (bd_n) ins_cnt <= '0;
      else if (ms_tick && ins_cnt != FULL) ins_cnt <= ins_cnt + 1'b1;

      if (ov_flag) ov_blk <= 1'b1;
      else if (ov_rel || ins_edge) ov_blk <= 1'b0;
      if (uv_flag) uv_blk <= 1'b1;
      else if (uv_rel || ins_edge) uv_blk <= 1'b0;
    end
  end

  a_r1_ov_logged: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_flag) |=> flt_d[0]);
  a_r2_uv_logged: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_flag) |=> flt_d[1]);
  a_r3_release_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ov_blk) |-> !$past(ov_flag));
  a_r7_removal_drops_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bd_n) |=> !ctl_a[3]);
  a_r10_short_logged: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_short && !gate_en) |=> flt_d[5]);
  a_r13_pd_single: assert property (@(posedge clk) disable iff (!rst_n)
    gate_pd |=> !gate_pd);
endmodule

// File: tb/sim_hsw_fault_ctrl.sv
module sim_hsw_fault_ctrl;
  localparam int CLK_PER = 10;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic ms_tick = 0, uvlo_rel = 0, ov_flag = 0, uv_flag = 0, bd_n = 1;
  logic on_pin = 0, fet_short = 0, wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctl_a, stat_c, flt_d;
  logic gate_en, gate_pd;

  int total = 0, bad = 0;
  bit done = 0;

  bit m_a0, m_a1, m_a3, m_ovb, m_uvb, m_ovq, m_uvq, m_bdq, m_gq;
  int m_ovc, m_uvc, m_insc;
  logic [7:0] m_d;

  hsw_fault_ctrl #(.QUAL_TICKS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .uvlo_rel(uvlo_rel),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .bd_n(bd_n), .on_pin(on_pin),
    .fet_short(fet_short), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctl_a(ctl_a), .stat_c(stat_c), .flt_d(flt_d),
    .gate_en(gate_en), .gate_pd(gate_pd));

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h t=%0t", req, what, got, exp, $time);
    end
  endtask

  function automatic bit e_gate();
    return m_a3 && !ov_flag && !uv_flag && !bd_n && !m_ovb && !m_uvb;
  endfunction
  function automatic bit e_pd();
    return m_gq && !e_gate() && (ov_flag || uv_flag || bd_n);
  endfunction
  function automatic logic [7:0] e_stat();
    logic [7:0] s = 8'h00;
    s[0] = ov_flag; s[1] = uv_flag; s[4] = !bd_n; s[5] = fet_short && !e_gate();
    return s;
  endfunction
  function automatic logic [7:0] e_ctl();
    logic [7:0] c = 8'h00;
    c[0] = m_a0; c[1] = m_a1; c[3] = m_a3;
    return c;
  endfunction

  task automatic model_step();
    bit g, ins, rem, ovr, uvr, ld;
    logic [7:0] st, cl;
    g = e_gate();
    ins = m_bdq && !bd_n; rem = !m_bdq && bd_n;
    ovr = m_ovb && !ov_flag && m_ovc == N && m_a0;
    uvr = m_uvb && !uv_flag && m_uvc == N && m_a1;
    ld = !bd_n && ms_tick && m_insc == N-1;
    st = 8'h00;
    st[0] = ov_flag && !m_ovq;
    st[1] = (uv_flag && !m_uvq) || (uvlo_rel && uv_flag);
    st[4] = m_bdq != bd_n;
    st[5] = fet_short && !g;
    cl = (wr_en && wr_sel) ? wr_data : 8'h00;
    if (ins) cl = cl | 8'hEF;
    m_d = ((m_d & ~cl) | st) & 8'h33;
    if (wr_en && !wr_sel) begin m_a0 = wr_data[0]; m_a1 = wr_data[1]; end
    if (rem) m_a3 = 0;
    else if (ld) m_a3 = on_pin;
    else if (wr_en && !wr_sel) m_a3 = wr_data[3];
    m_ovc = ov_flag ? 0 : (ms_tick && m_ovc != N) ? m_ovc + 1 : m_ovc;
    m_uvc = uv_flag ? 0 : (ms_tick && m_uvc != N) ? m_uvc + 1 : m_uvc;
    m_insc = bd_n ? 0 : (ms_tick && m_insc != N) ? m_insc + 1 : m_insc;
    m_ovb = ov_flag ? 1 : (ovr || ins) ? 0 : m_ovb;
    m_uvb = uv_flag ? 1 : (uvr || ins) ? 0 : m_uvb;
    m_gq = g; m_ovq = ov_flag; m_uvq = uv_flag; m_bdq = bd_n;
  endtask

  task automatic cyc();
    #1;
    chk("R1/R2/R3/R4/R7/R9", "gate_en", {7'b0, gate_en}, {7'b0, e_gate()});
    chk("R13", "gate_pd", {7'b0, gate_pd}, {7'b0, e_pd()});
    chk("R10", "stat_c", stat_c, e_stat());
    chk("R6/R8/R11", "flt_d", flt_d, m_d);
    chk("R12", "ctl_a", ctl_a, e_ctl());
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1; cyc(); ms_tick = 0; cyc();
    end
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; cyc(); wr_en = 0;
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    m_a0 = 1; m_a1 = 1; m_a3 = 0; m_ovb = 0; m_uvb = 0; m_gq = 0;
    m_ovc = 0; m_uvc = 0; m_insc = 0; m_d = 0;
    m_ovq = 0; m_uvq = 0; m_bdq = 1;
    #(CLK_PER * 3 + 2);
    chk("R12", "reset ctl", ctl_a, 8'h03);
    chk("R12", "reset flt", flt_d, 8'h00);
    chk("R12", "reset gate", {7'b0, gate_en}, 8'h00);
    @(negedge clk); rst_n = 1;

    bd_n = 0; on_pin = 1;
    #1; chk("R8", "seated status", {7'b0, stat_c[4]}, 8'h01);
    cyc();
    chk("R6", "toggle logged", {7'b0, flt_d[4]}, 8'h01);
    ticks(N - 1);
    chk("R9", "not yet loaded", {7'b0, ctl_a[3]}, 8'h00);
    ticks(1);
    chk("R9", "on loaded", {7'b0, ctl_a[3]}, 8'h01);
    chk("R9", "gate on", {7'b0, gate_en}, 8'h01);

    ov_flag = 1; #1;
    chk("R1", "gate off same cycle", {7'b0, gate_en}, 8'h00);
    chk("R13", "pulldown strobe", {7'b0, gate_pd}, 8'h01);
    cyc();
    chk("R1", "fault bit 0", {7'b0, flt_d[0]}, 8'h01);
    chk("R13", "strobe one cycle", {7'b0, gate_pd}, 8'h00);
    ov_flag = 0; ticks(2); ov_flag = 1; cyc(); ov_flag = 0;
    ticks(N - 1);
    chk("R3", "restarted count holds off", {7'b0, gate_en}, 8'h00);
    ticks(1); cyc();
    chk("R3", "retry after qualify", {7'b0, gate_en}, 8'h01);

    wr(0, 8'h0A);
    chk("R12", "ctl write", ctl_a, 8'h0A);
    ov_flag = 1; cyc(); ov_flag = 0;
    ticks(5 * N);
    chk("R4", "no retry when disabled", {7'b0, gate_en}, 8'h00);
    fet_short = 1; #1;
    chk("R10", "short status", {7'b0, stat_c[5]}, 8'h01);
    cyc(); fet_short = 0;
    chk("R10", "short fault", {7'b0, flt_d[5]}, 8'h01);
    bd_n = 1; cyc(); cyc();
    chk("R7", "removal clears on", {7'b0, ctl_a[3]}, 8'h00);
    bd_n = 0; cyc();
    chk("R8", "insert clears faults", flt_d & 8'h23, 8'h00);
    ticks(N); cyc();
    chk("R8", "insert lifts block", {7'b0, gate_en}, 8'h01);

    wr(0, 8'h03);
    chk("R13", "soft off no strobe", {7'b0, gate_pd}, 8'h00);
    uv_flag = 1; cyc(); wr(1, 8'hFF);
    chk("R11", "w1c clears", flt_d, 8'h00);
    uvlo_rel = 1; cyc(); uvlo_rel = 0;
    chk("R5", "lockout release logs", {7'b0, flt_d[1]}, 8'h01);
    chk("R2", "uv status", {7'b0, stat_c[1]}, 8'h01);
    uv_flag = 0; cyc();

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(39) == 0) ov_flag = ~ov_flag;
      if ($urandom_range(39) == 0) uv_flag = ~uv_flag;
      if ($urandom_range(59) == 0) bd_n = ~bd_n;
      if ($urandom_range(19) == 0) on_pin = ~on_pin;
      fet_short = ($urandom_range(7) == 0);
      ms_tick = ($urandom_range(2) == 0);
      uvlo_rel = ($urandom_range(49) == 0);
      wr_en = ($urandom_range(29) == 0);
      wr_sel = $urandom_range(1);
      wr_data = 8'($urandom);
      cyc();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule